// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block chooses which physical frame to give up when a new page has to be brought in. It uses the clock approximation of not-recently-used replacement. For each of `ENTRIES` frames it keeps a referenced flag and a modified flag, plus a circular hand that marks the frame most recently chosen. The memory pipeline reports every access on the touch port, and a write access also marks the frame modified.

When the paging logic asks for a victim, the hand moves one frame per cycle. Each referenced frame it passes gets a second chance: its referenced flag is cleared. The sweep stops at the first frame that is unreferenced. In clean-first mode the first full lap accepts only a frame that is both unreferenced and unmodified. If that lap finds none, the sweep takes the first unreferenced frame it meets after the lap.

The result comes back as a single-cycle pulse with the frame index and its modified flag. The caller uses the modified flag to decide whether a write-back is needed before the frame is reused.

Top module: `clock_nru_selector`

## Requirements
- R1: After reset every referenced and modified flag is 0, `busy` and `victim_valid` are 0, and the hand rests on entry `ENTRIES-1`, so the first sweep examines entry 0 first.
- R2: A touch sets the referenced flag of `touch_idx` in the next cycle. A touch with `touch_write`=1 also sets its modified flag. Only reset clears a modified flag.
- R3: A `victim_req` sampled while idle raises `busy` in the next cycle. From the following cycle, exactly one entry is examined per cycle, starting at the entry after the hand and wrapping from `ENTRIES-1` to 0.
- R4: In plain mode (`prefer_clean`=0 at acceptance) the victim is the first examined entry whose referenced flag is 0. Every examined entry that is passed over has its referenced flag cleared.
- R5: The hand stays on the chosen victim, so the next sweep begins at the entry after it.
- R6: When entry k is accepted in a given cycle, the next cycle carries `victim_valid`=1 for exactly one cycle, with `victim_idx`=k and `victim_dirty` equal to k's modified flag as examined. `busy` is 0 in that cycle. A sweep that makes n examinations therefore reports n cycles after `busy` rises.
- R7: In clean-first mode (`prefer_clean`=1 at acceptance) the first `ENTRIES` examinations accept only an entry whose referenced and modified flags are both 0. Referenced entries passed during that lap are cleared.
- R8: If a clean-first lap of `ENTRIES` examinations accepts nothing, every later examination in that sweep accepts any entry whose referenced flag is 0, whatever its modified flag.
- R9: If a touch and a sweep clear reach the same entry in the same cycle, the entry's referenced flag is 1 afterwards.
- R10: A `victim_req` that arrives while `busy` is 1 is ignored, together with its `prefer_clean`. The running sweep's result and timing do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_en | input | 1 | An access to frame `touch_idx` happened |
| touch_idx | input | IDX_W | Frame that was accessed |
| touch_write | input | 1 | The access was a write (sets the modified flag) |
| victim_req | input | 1 | Ask for a victim frame |
| prefer_clean | input | 1 | Clean-first mode for the request being accepted |
| busy | output | 1 | A sweep is in progress |
| victim_valid | output | 1 | One-cycle pulse: the victim is reported |
| victim_idx | output | IDX_W | Chosen frame |
| victim_dirty | output | 1 | Modified flag of the chosen frame |

## Verification
The bench builds the block with `ENTRIES`=4. With this value a full lap takes only four examinations, so a bench run reaches the wrap from 3 to 0 many times, the clean-first fallback, and a two-lap sweep in a few cycles. The directed sequence arranges the flags so that each sweep has a hand-computed victim, modified flag and latency. In one sweep a touch lands on the very entry being cleared. In another, a second request arrives mid-sweep with the opposite mode. A behavioural model runs alongside and is compared on every cycle.

// File: rtl/clock_nru_pkg.sv
package clock_nru_pkg;

    typedef enum logic [0:0] {
        SWEEP_IDLE = 1'b0,
        SWEEP_SCAN = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/nru_flag_bank.sv
module nru_flag_bank #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic               touch_wr,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [ENTRIES-1:0] ref_o,
    output logic [ENTRIES-1:0] dirty_o
);

    typedef struct packed {
        logic [ENTRIES-1:0] refb;
        logic [ENTRIES-1:0] dirty;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [ENTRIES-1:0] set_v;
    logic [ENTRIES-1:0] wr_v;
    logic [ENTRIES-1:0] clr_v;

    // Per-slot decode of the touch and sweep-clear indices.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign set_v[g] = touch_en && (touch_idx == IDX_W'(g));
        assign wr_v[g]  = set_v[g] && touch_wr;
        assign clr_v[g] = clr_en && (clr_idx == IDX_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        // Setting is applied after clearing, so a touch wins a collision.
        bank_d.refb  = (bank_q.refb & ~clr_v) | set_v;
        bank_d.dirty = bank_q.dirty | wr_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign ref_o   = bank_q.refb;
    assign dirty_o = bank_q.dirty;

    // R2: an access is remembered in the next cycle
    p_touch_sets_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> ref_o[$past(touch_idx)]);

    // R2: modified flags only ever rise
    p_dirty_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dirty_o & $past(dirty_o)) == '0));

    // R4 / R9: a cleared entry drops unless a touch lands on it too
    p_clear_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(touch_en && touch_idx == clr_idx)) |=> !ref_o[$past(clr_idx)]);

endmodule

// File: rtl/nru_sweep_ctrl.sv
module nru_sweep_ctrl
    import clock_nru_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               prefer_clean,
    input  logic [ENTRIES-1:0] ref_i,
    input  logic [ENTRIES-1:0] dirty_i,
    output logic               clr_en,
    output logic [IDX_W-1:0]   clr_idx,
    output logic               busy,
    output logic               victim_valid,
    output logic [IDX_W-1:0]   victim_idx,
    output logic               victim_dirty
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [CNT_W-1:0] LAP_END  = CNT_W'(ENTRIES - 1);

    typedef struct packed {
        sweep_state_e     st;
        logic [IDX_W-1:0] hand;
        logic             clean_mode;
        logic             fallback;
        logic [CNT_W-1:0] seen;
        logic             vld;
        logic [IDX_W-1:0] vidx;
        logic             vdirty;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [IDX_W-1:0] cand;
    logic             strict;
    logic             take;

    always_comb begin
        cand    = (ctrl_q.hand == LAST_IDX) ? '0 : ctrl_q.hand + 1'b1;
        strict  = ctrl_q.clean_mode && !ctrl_q.fallback;
        take    = !ref_i[cand] && (!strict || !dirty_i[cand]);

        ctrl_d     = ctrl_q;
        ctrl_d.vld = 1'b0;
        clr_en     = 1'b0;
        clr_idx    = cand;

        unique case (ctrl_q.st)
            SWEEP_IDLE: begin
                if (req) begin
                    ctrl_d.st         = SWEEP_SCAN;
                    ctrl_d.clean_mode = prefer_clean;
                    ctrl_d.fallback   = 1'b0;
                    ctrl_d.seen       = '0;
                end
            end
            SWEEP_SCAN: begin
                ctrl_d.hand = cand;
                if (take) begin
                    ctrl_d.st     = SWEEP_IDLE;
                    ctrl_d.vld    = 1'b1;
                    ctrl_d.vidx   = cand;
                    ctrl_d.vdirty = dirty_i[cand];
                end else begin
                    clr_en = 1'b1;
                    if (ctrl_q.seen == LAP_END) begin
                        ctrl_d.seen = '0;
                        if (ctrl_q.clean_mode) begin
                            ctrl_d.fallback = 1'b1;
                        end
                    end else begin
                        ctrl_d.seen = ctrl_q.seen + 1'b1;
                    end
                end
            end
            default: ctrl_d.st = SWEEP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            ctrl_q.st   <= SWEEP_IDLE;
            ctrl_q.hand <= LAST_IDX;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy         = (ctrl_q.st == SWEEP_SCAN);
    assign victim_valid = ctrl_q.vld;
    assign victim_idx   = ctrl_q.vidx;
    assign victim_dirty = ctrl_q.vdirty;

    // R6: the report is a single-cycle pulse
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid);

    // R6: the report ends a sweep and busy is already low
    p_report_ends_sweep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (!busy && $past(busy)));

    // R3: while sweeping, the hand moves by exactly one entry each cycle
    p_hand_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (ctrl_q.hand == (($past(ctrl_q.hand) == LAST_IDX) ? '0 : $past(ctrl_q.hand) + 1'b1)));

    // R7: a victim taken during the strict lap is unmodified
    p_clean_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && $past(strict)) |-> !victim_dirty);

    // R5: the hand rests on the reported victim
    p_hand_on_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (ctrl_q.hand == victim_idx));

endmodule

// File: rtl/clock_nru_selector.sv
module clock_nru_selector #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_write,
    input  logic             victim_req,
    input  logic             prefer_clean,
    output logic             busy,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_dirty
);

    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0] ref_bits;
    logic [ENTRIES-1:0] dirty_bits;
    logic               clr_en;
    logic [IDX_W-1:0]   clr_idx;

    nru_flag_bank #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) i_flag_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_wr  (touch_write),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .ref_o     (ref_bits),
        .dirty_o   (dirty_bits)
    );

    nru_sweep_ctrl #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) i_sweep_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (victim_req),
        .prefer_clean (prefer_clean),
        .ref_i        (ref_bits),
        .dirty_i      (dirty_bits),
        .clr_en       (clr_en),
        .clr_idx      (clr_idx),
        .busy         (busy),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx),
        .victim_dirty (victim_dirty)
    );

endmodule

// File: tb/test_clock_nru_selector.sv
module test_clock_nru_selector;

    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          touch_en = 1'b0;
    logic [IW-1:0] touch_idx = '0;
    logic          touch_write = 1'b0;
    logic          victim_req = 1'b0;
    logic          prefer_clean = 1'b0;
    logic          busy;
    logic          victim_valid;
    logic [IW-1:0] victim_idx;
    logic          victim_dirty;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2ns clk = ~clk;

    clock_nru_selector #(.ENTRIES(N)) i_clock_nru_selector (
        .clk          (clk),
        .rst_n        (rst_n),
        .touch_en     (touch_en),
        .touch_idx    (touch_idx),
        .touch_write  (touch_write),
        .victim_req   (victim_req),
        .prefer_clean (prefer_clean),
        .busy         (busy),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx),
        .victim_dirty (victim_dirty)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on each rising edge.
    int mref[N];
    int mdir[N];
    int mhand, mcnt, midx, mdty;
    bit mbusy, mvld, mclean, mlap2;

    always @(posedge clk) begin
        int cand;
        int clr;
        bit ok;
        clr = -1;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mref[i] = 0;
                mdir[i] = 0;
            end
            mhand = N - 1; mbusy = 0; mvld = 0; mcnt = 0; mclean = 0; mlap2 = 0;
            midx = 0; mdty = 0;
        end else begin
            mvld = 0;
            if (mbusy) begin
                cand = (mhand + 1) % N;
                ok = (mref[cand] == 0) && (!(mclean && !mlap2) || mdir[cand] == 0);
                mhand = cand;
                if (ok) begin
                    mvld = 1; midx = cand; mdty = mdir[cand]; mbusy = 0;
                end else begin
                    clr = cand;
                    mcnt++;
                    if (mcnt == N) begin
                        mcnt = 0;
                        if (mclean) mlap2 = 1;
                    end
                end
            end else if (victim_req) begin
                mbusy = 1; mclean = prefer_clean; mlap2 = 0; mcnt = 0;
            end
            if (clr >= 0) mref[clr] = 0;
            if (touch_en) begin
                mref[touch_idx] = 1;
                if (touch_write) mdir[touch_idx] = 1;
            end
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == mbusy, "R3 busy vs model", int'(busy), int'(mbusy));
            check(victim_valid == mvld, "R6 valid vs model", int'(victim_valid), int'(mvld));
            if (mvld) begin
                check(int'(victim_idx) == midx, "R4 index vs model", int'(victim_idx), midx);
                check(int'(victim_dirty) == mdty, "R6 dirty vs model", int'(victim_dirty), mdty);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic touch(input int idx, input bit wr);
        @(negedge clk);
        touch_en = 1'b1; touch_idx = IW'(idx); touch_write = wr;
        @(negedge clk);
        touch_en = 1'b0; touch_write = 1'b0;
    endtask

    // Issue a request, optionally touch or re-request in the first sweep cycle,
    // then check the reported victim, its modified flag and the latency.
    task automatic sweep(input bit clean, input int exp_idx, input bit exp_d,
                         input int exp_lat, input int touch_at, input bit extra_req,
                         input string tag);
        int lat;
        @(negedge clk);
        victim_req = 1'b1; prefer_clean = clean;
        @(negedge clk);
        victim_req = 1'b0;
        check(busy == 1'b1, {tag, " R3 busy after request"}, int'(busy), 1);
        if (touch_at >= 0) begin
            touch_en = 1'b1; touch_idx = IW'(touch_at); touch_write = 1'b0;
        end
        if (extra_req) begin
            victim_req = 1'b1; prefer_clean = !clean;
        end
        lat = 0;
        do begin
            @(negedge clk);
            touch_en = 1'b0; victim_req = 1'b0;
            lat++;
        end while (!victim_valid && lat < 40);
        check(victim_valid == 1'b1, {tag, " R6 report seen"}, int'(victim_valid), 1);
        check(int'(victim_idx) == exp_idx, {tag, " victim index"}, int'(victim_idx), exp_idx);
        check(victim_dirty == exp_d, {tag, " R6 victim dirty"}, int'(victim_dirty), int'(exp_d));
        check(lat == exp_lat, {tag, " R6 latency"}, lat, exp_lat);
        check(busy == 1'b0, {tag, " R6 busy low at report"}, int'(busy), 0);
        @(negedge clk);
        check(victim_valid == 1'b0, {tag, " R6 pulse one cycle"}, int'(victim_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        check(victim_valid == 1'b0, "R1 valid in reset", int'(victim_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

        // R1, R4: all clear, first examined entry is 0
        sweep(1'b0, 0, 1'b0, 1, -1, 1'b0, "R1 first sweep");
        // R4: entries 1 and 2 get a second chance, 3 is taken
        touch(1, 1'b0);
        touch(2, 1'b1);
        sweep(1'b0, 3, 1'b0, 3, -1, 1'b0, "R4 second chance");
        // R5: next sweep starts after 3, wraps to 0
        sweep(1'b0, 0, 1'b0, 1, -1, 1'b0, "R5 hand wrap");
        // R7: skip modified 2 and referenced 1, 3; take clean 0
        touch(1, 1'b1);
        touch(3, 1'b0);
        sweep(1'b1, 0, 1'b0, 4, -1, 1'b0, "R7 clean first");
        // R8, R10, R2: every entry modified, fallback takes 1 (modified by write)
        touch(0, 1'b1);
        touch(3, 1'b1);
        sweep(1'b1, 1, 1'b1, 5, -1, 1'b1, "R8 R10 fallback");
        // R9: touch collides with clear of entry 2; 3 taken
        touch(2, 1'b0);
        sweep(1'b0, 3, 1'b1, 2, 2, 1'b0, "R9 collision");
        // R9: entry 2 kept its flag, so the sweep passes it and reaches 3
        touch(0, 1'b0);
        touch(1, 1'b0);
        sweep(1'b0, 3, 1'b1, 4, -1, 1'b0, "R9 flag kept");
        // R2: modified flag of 0 persists, plain sweep takes 0 next
        sweep(1'b0, 0, 1'b1, 1, -1, 1'b0, "R2 dirty sticky");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule